// File: doc/BRIEF.md
# Single-Bit Hamming Sector Checker and Fixer

This block closes the read path of a NAND sector protected by a single-error-correcting Hamming code. After a sector has streamed in, the controller hands over two values: the raw 32-bit parity word it accumulated while reading, and the three code bytes that were stored with the sector in its spare area. A one-cycle start pulse launches the check. The block compacts the parity word into a 24-bit code, inverts it, XORs it against the stored code, and sorts the outcome into clean, fixed or beyond repair.

When the difference points at one data bit, the block repairs that bit in place. It reads the affected byte from the sector buffer through a byte-wide port with a one-cycle read latency, flips the bit and writes the byte back. The verdict, the position it repaired and a one-cycle done strobe are presented when the work is finished. The verdict stays on the outputs until the next accepted start.

Top module: `hamming_sector_fixer`

## Requirements
- R1: The parity word's bits 31:28 and 15:12 have no effect on the result. The calculated code is the bitwise inverse of {raw[27:16], raw[11:0]}. An all-ones stored code checked against a raw word whose code bits are all zero therefore reports status 0.
- R2: The stored code is stored_ecc_i, with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. The difference is the stored code XOR the calculated code.
- R3: A zero difference gives status 0 (passed), reports fix byte 0 and fix bit 0, and makes no access to the buffer.
- R4: A difference whose bits 23:12 XOR bits 11:0 equal 0xFFF is correctable. The byte index is difference bits 23:15 and the bit index is bits 14:12. When the byte index is below SECTOR_BYTES, the block issues exactly one buffer read and then, in the next cycle, one write at that address. The write data is the read data with only that bit inverted. Status is 1, and fix_byte_o and fix_bit_o show the position.
- R5: A correctable pattern whose byte index is SECTOR_BYTES or above gives status 2 and no buffer access.
- R6: A difference that is not correctable but has exactly one bit set gives status 1. It reports fix byte 0 and fix bit 0 and makes no buffer access.
- R7: Every other non-zero difference gives status 2 and no buffer access.
- R8: done_o is a one-cycle pulse. It comes 1 cycle after the start edge when no repair is made, and 3 cycles after when a repair is made. status_o, fix_byte_o and fix_bit_o hold their values until the next accepted start.
- R9: busy_o is high from the edge that accepts start until the cycle of done_o, inclusive. A start pulse while busy_o is high is ignored.
- R10: After reset, busy_o, done_o, buf_rd_o and buf_wr_o are 0 and status_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a check |
| parity_raw_i | input | 32 | Raw parity word computed over the sector |
| stored_ecc_i | input | 24 | Three stored code bytes, byte 0 lowest |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 2 | 0 passed, 1 corrected, 2 uncorrectable |
| fix_byte_o | output | 9 | Byte index that was repaired |
| fix_bit_o | output | 3 | Bit index that was repaired |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_rd_o | output | 1 | Buffer read strobe; data is returned the next cycle |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |

## Verification
A wrong latched verdict is visible at status_o on the first done_o pulse, one or three cycles after start. A corrupted byte or bit index shows at the ports in two ways: as a buffer write to the wrong address, and as a wrong bit flipped in the sector shadow by the time done_o rises. A sequencer that skips or repeats a state changes the done_o latency or the number of read and write strobes. The check therefore fails within the same transaction. Random differences are drawn in three groups: correctable patterns whose byte index falls on either side of a reduced sector limit, single-bit codes, and arbitrary words. Each group is checked against a bench model of the classification rules.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int RAW_W   = 32;
  localparam int HALF_W  = 12;
  localparam int CODE_W  = 2 * HALF_W;
  localparam int UPPER_LSB = RAW_W / 2;
  localparam int BIT_W   = 3;
  localparam int BYTE_W  = 1 << BIT_W;
  localparam int POS_W   = CODE_W - HALF_W - BIT_W;
  localparam int ECC_BYTES = CODE_W / BYTE_W;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_FIXED = 2'd1,
    ST_FAIL  = 2'd2
  } ecc_status_e;

  typedef struct packed {
    ecc_status_e          status;
    logic                 fix;
    logic [POS_W-1:0]     byte_pos;
    logic [BIT_W-1:0]     bit_pos;
  } verdict_t;
endpackage

// File: rtl/hecc_code_diff.sv
module hecc_code_diff
  import hecc_pkg::*;
(
  input  logic [RAW_W-1:0]          raw_i,
  input  logic [ECC_BYTES*BYTE_W-1:0] stored_i,
  output logic [CODE_W-1:0]         diff_o
);
  logic [CODE_W-1:0] calc_code;
  logic [CODE_W-1:0] stored_code;
  logic              unused_reserved;

  // reserved nibbles dropped, then inverted so an erased page reads clean
  assign calc_code = ~{raw_i[UPPER_LSB +: HALF_W], raw_i[0 +: HALF_W]};
  assign unused_reserved = ^{raw_i[RAW_W-1 -: (UPPER_LSB - HALF_W)],
                             raw_i[UPPER_LSB-1 -: (UPPER_LSB - HALF_W)]};

  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_le
    assign stored_code[g*BYTE_W +: BYTE_W] = stored_i[g*BYTE_W +: BYTE_W];
  end

  assign diff_o = stored_code ^ calc_code;
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] diff_i,
  output verdict_t          verdict_o
);
  localparam logic [POS_W:0] LIMIT = (POS_W+1)'(SECTOR_BYTES);

  logic [HALF_W-1:0] fold;
  logic              pattern_ok;
  logic              in_range;
  logic              single_bit;
  logic [POS_W-1:0]  pos;
  logic [BIT_W-1:0]  bpos;

  assign fold       = diff_i[CODE_W-1:HALF_W] ^ diff_i[HALF_W-1:0];
  assign pattern_ok = &fold;
  assign pos        = diff_i[CODE_W-1 -: POS_W];
  assign bpos       = diff_i[HALF_W +: BIT_W];
  assign in_range   = {1'b0, pos} < LIMIT;
  assign single_bit = $onehot(diff_i);

  always_comb begin
    verdict_o          = '0;
    verdict_o.status   = ST_PASS;
    if (diff_i == '0) begin
      verdict_o.status = ST_PASS;
    end else if (pattern_ok) begin
      if (in_range) begin
        verdict_o.status   = ST_FIXED;
        verdict_o.fix      = 1'b1;
        verdict_o.byte_pos = pos;
        verdict_o.bit_pos  = bpos;
      end else begin
        verdict_o.status = ST_FAIL;
      end
    end else if (single_bit) begin
      verdict_o.status = ST_FIXED;
    end else begin
      verdict_o.status = ST_FAIL;
    end
  end
endmodule

// File: rtl/hecc_rmw_seq.sv
module hecc_rmw_seq
  import hecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  verdict_t          verdict_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [POS_W-1:0]  fix_byte_o,
  output logic [BIT_W-1:0]  fix_bit_o,
  output logic [POS_W-1:0]  buf_addr_o,
  output logic              buf_rd_o,
  input  logic [BYTE_W-1:0] buf_rdata_i,
  output logic              buf_wr_o,
  output logic [BYTE_W-1:0] buf_wdata_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} seq_e;

  seq_e              state_q;
  ecc_status_e       status_q;
  logic [POS_W-1:0]  byte_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] flip_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_PASS;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          status_q <= verdict_i.status;
          byte_q   <= verdict_i.byte_pos;
          bit_q    <= verdict_i.bit_pos;
          state_q  <= verdict_i.fix ? S_RD : S_FIN;
        end
        S_RD:    state_q <= S_WR;
        S_WR:    state_q <= S_FIN;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < BYTE_W; g++) begin : g_mask
    assign flip_mask[g] = (bit_q == BIT_W'(g));
  end

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = state_q == S_FIN;
  assign status_o    = status_q;
  assign fix_byte_o  = byte_q;
  assign fix_bit_o   = bit_q;
  assign buf_addr_o  = byte_q;
  assign buf_rd_o    = state_q == S_RD;
  assign buf_wr_o    = state_q == S_WR;
  assign buf_wdata_o = buf_rdata_i ^ flip_mask;
endmodule

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [RAW_W-1:0]            parity_raw_i,
  input  logic [ECC_BYTES*BYTE_W-1:0] stored_ecc_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [1:0]                  status_o,
  output logic [POS_W-1:0]            fix_byte_o,
  output logic [BIT_W-1:0]            fix_bit_o,
  output logic [POS_W-1:0]            buf_addr_o,
  output logic                        buf_rd_o,
  input  logic [BYTE_W-1:0]           buf_rdata_i,
  output logic                        buf_wr_o,
  output logic [BYTE_W-1:0]           buf_wdata_o
);
  logic [CODE_W-1:0] diff;
  verdict_t          verdict;

  hecc_code_diff u_diff (
    .raw_i    (parity_raw_i),
    .stored_i (stored_ecc_i),
    .diff_o   (diff)
  );

  hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .diff_i    (diff),
    .verdict_o (verdict)
  );

  hecc_rmw_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .verdict_i   (verdict),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .fix_byte_o  (fix_byte_o),
    .fix_bit_o   (fix_bit_o),
    .buf_addr_o  (buf_addr_o),
    .buf_rd_o    (buf_rd_o),
    .buf_rdata_i (buf_rdata_i),
    .buf_wr_o    (buf_wr_o),
    .buf_wdata_o (buf_wdata_o)
  );
endmodule

// File: rtl/hecc_checker.sv
module hecc_checker
  import hecc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       status_o,
  input logic [POS_W-1:0] buf_addr_o,
  input logic             buf_rd_o,
  input logic             buf_wr_o
);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(buf_rd_o || buf_wr_o));

  a_r4_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |=> (buf_wr_o && $stable(buf_addr_o)));

  a_r4_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $past(buf_rd_o));

  a_r8_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(status_o));

  a_r5_no_write_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd2) |-> !$past(buf_wr_o));
endmodule

bind hamming_sector_fixer hecc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .status_o   (status_o),
  .buf_addr_o (buf_addr_o),
  .buf_rd_o   (buf_rd_o),
  .buf_wr_o   (buf_wr_o)
);

// File: tb/hamming_sector_fixer_tb.sv
`timescale 1ns/1ps
module hamming_sector_fixer_tb;
  localparam int SECTOR = 384;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] parity_raw_i = '0;
  logic [23:0] stored_ecc_i = '0;
  logic        busy_o, done_o, buf_rd_o, buf_wr_o;
  logic [1:0]  status_o;
  logic [8:0]  fix_byte_o, buf_addr_o;
  logic [2:0]  fix_bit_o;
  logic [7:0]  buf_rdata_i, buf_wdata_o;

  logic [7:0] mem    [SECTOR];
  logic [7:0] shadow [SECTOR];
  int rd_cnt, wr_cnt, done_cnt;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  hamming_sector_fixer #(.SECTOR_BYTES(SECTOR)) u_dut (
    .clk_i, .rst_ni, .start_i, .parity_raw_i, .stored_ecc_i,
    .busy_o, .done_o, .status_o, .fix_byte_o, .fix_bit_o,
    .buf_addr_o, .buf_rd_o, .buf_rdata_i, .buf_wr_o, .buf_wdata_o
  );

  always @(posedge clk_i) begin
    if (buf_rd_o) begin buf_rdata_i <= mem[buf_addr_o]; rd_cnt <= rd_cnt + 1; end
    if (buf_wr_o) begin mem[buf_addr_o] <= buf_wdata_o; wr_cnt <= wr_cnt + 1; end
    if (done_o) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] code_of(input logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  // expected verdict from the requirements
  function automatic void model(input logic [23:0] d, output int st, output bit fix,
                                output int bpos, output int bitp);
    fix = 0; bpos = 0; bitp = 0;
    if (d == 0) st = 0;
    else if ((d[23:12] ^ d[11:0]) == 12'hFFF) begin
      if (int'(d[23:15]) < SECTOR) begin
        st = 1; fix = 1; bpos = int'(d[23:15]); bitp = int'(d[14:12]);
      end else st = 2;
    end else if ($countones(d) == 1) st = 1;
    else st = 2;
  endfunction

  task automatic run(input logic [31:0] raw, input logic [23:0] stored,
                     input string req, input bit poke_busy);
    int st, bp, bt, lat, d0;
    bit fix, mem_ok;
    model(stored ^ code_of(raw), st, fix, bp, bt);
    @(negedge clk_i);
    rd_cnt = 0; wr_cnt = 0; d0 = done_cnt;
    start_i = 1; parity_raw_i = raw; stored_ecc_i = stored;
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o, "R9", "busy after start", busy_o, 1);
    if (poke_busy) begin
      start_i = 1; parity_raw_i = $urandom; stored_ecc_i = 24'h123456;
    end
    lat = 1;
    while (!done_o && lat < 10) begin
      @(negedge clk_i); start_i = 0; lat++;
    end
    start_i = 0;
    chk(lat == (fix ? 3 : 1), "R8", {req, " done latency"}, lat, fix ? 3 : 1);
    chk(status_o == 2'(st), req, "status", status_o, st);
    chk(fix_byte_o == 9'(bp) && fix_bit_o == 3'(bt), req, "fix position",
        {fix_byte_o, fix_bit_o}, (bp << 3) | bt);
    chk(rd_cnt == int'(fix) && wr_cnt == int'(fix), req, "buffer accesses",
        rd_cnt * 16 + wr_cnt, fix * 17);
    if (fix) shadow[bp] = shadow[bp] ^ (8'h1 << bt);
    mem_ok = 1;
    for (int i = 0; i < SECTOR; i++) if (mem[i] !== shadow[i]) mem_ok = 0;
    chk(mem_ok, req, "sector contents", mem_ok, 1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R8", "done single pulse", done_o, 0);
    if (poke_busy) begin
      repeat (4) @(negedge clk_i);
      chk(done_cnt == d0 + 1, "R9", "start while busy ignored", done_cnt - d0, 1);
      chk(status_o == 2'(st), "R8", "status held", status_o, st);
    end
  endtask

  function automatic logic [23:0] corr_diff(input logic [8:0] b, input logic [2:0] t);
    logic [11:0] up;
    up = {b, t};
    return {up, ~up};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < SECTOR; i++) begin
      mem[i] = 8'($urandom); shadow[i] = mem[i];
    end
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !buf_rd_o && !buf_wr_o && status_o == 0,
        "R10", "reset state", {busy_o, done_o, buf_rd_o, buf_wr_o, status_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && status_o == 0, "R10", "idle after reset", busy_o, 0);

    // R1: erased page with reserved bits set checks clean
    run(32'hF000_F000, 24'hFF_FFFF, "R1", 0);
    run(32'h0000_0000, 24'hFF_FFFF, "R1", 0);
    // R2: byte order of stored code, bit 0 of byte 2 only
    run(32'h0000_0000, 24'hFE_FFFF, "R2", 0);
    // R4 boundaries
    run(32'h0000_0000, ~corr_diff(9'd0, 3'd0), "R4", 0);
    run(32'h0000_0000, ~corr_diff(9'd383, 3'd7), "R4", 1);
    // R5: first byte index beyond the sector
    run(32'h0000_0000, ~corr_diff(9'd384, 3'd0), "R5", 0);
    run(32'h0000_0000, ~corr_diff(9'd511, 3'd7), "R5", 0);
    // R6 / R7 directed
    run(32'h1234_5678, code_of(32'h1234_5678) ^ 24'h00_0800, "R6", 0);
    run(32'h1234_5678, code_of(32'h1234_5678) ^ 24'h00_0003, "R7", 0);
    // R3 random clean
    for (int k = 0; k < 20; k++) begin
      logic [31:0] r = $urandom;
      run(r, code_of(r), "R3", 0);
    end
    // R4/R5 random correctable patterns
    for (int k = 0; k < 120; k++) begin
      logic [31:0] r = $urandom;
      logic [23:0] d = corr_diff(9'($urandom), 3'($urandom));
      run(r, code_of(r) ^ d, (int'(d[23:15]) < SECTOR) ? "R4" : "R5", (k % 8) == 0);
    end
    // R6 random single bit
    for (int k = 0; k < 30; k++) begin
      logic [31:0] r = $urandom;
      run(r, code_of(r) ^ (24'h1 << ($urandom % 24)), "R6", 0);
    end
    // R7 random other
    for (int k = 0; k < 60; k++) begin
      logic [31:0] r = $urandom;
      logic [23:0] d = 24'($urandom);
      run(r, code_of(r) ^ d, "R7", 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule